// File: doc/BRIEF.md
# Parallel SAR Converter Readout Controller

This block runs a 16-bit successive-approximation converter that has a parallel data bus. It drives three control lines toward the converter: an active-low read/convert strobe, an active-low chip select and a byte select. It watches the converter's busy flag. When a conversion finishes, the block reads the two's-complement result, either as one 16-bit word or as two bytes over eight data lines. It then hands the result to the host as a widened sample on a valid/ready stream.

A conversion is started by a level request or by a free-running mode. The same strobe that starts a conversion also enables the converter's output drivers, so the block orders its control lines carefully. It gives the strobe level time to settle before chip select changes. It waits for busy to rise before it enables the bus, and it waits a fixed access window after every byte-select change before it samples. All delays are parameters counted in system clock cycles. The busy flag is synchronized inside the block. A conversion whose busy flag never returns raises a sticky timeout flag. A sample that arrives while the previous one is still unaccepted raises a sticky overrun flag.

Top module: `sar_adc_rdctl`

## Requirements
- R1: A conversion is started by holding adc_rc_n and adc_cs_n both low for exactly PULSE_CYC consecutive clock cycles.
- R2: Whenever adc_cs_n falls, adc_rc_n has held its current level for at least SETUP_CYC cycles beforehand.
- R3: Starts of consecutive conversions are at least PERIOD_CYC cycles apart. start_req is a level request that is honoured only while the block is idle, and no conversion starts while start_req and cfg_free_run are both low.
- R4: The converter's bus is enabled (adc_rc_n high with adc_cs_n low) only after adc_busy has returned high for the current conversion, and never while adc_busy is low.
- R5: In word mode (cfg_byte_mode = 0), adc_byte stays 0 and the block captures all of adc_data[15:0] in the ACCESS_CYC-th cycle of bus enable.
- R6: In byte mode (cfg_byte_mode = 1), only adc_data[15:8] is read. With adc_byte = 0 it carries result bits 15..8 and is captured after ACCESS_CYC enabled cycles. adc_byte then goes to 1, and after ACCESS_CYC more cycles adc_data[15:8] is captured as result bits 7..0. adc_byte is 0 whenever adc_cs_n is high, and the mode is fixed for each conversion when that conversion starts.
- R7: smp_data holds the 16-bit result in bits 15..0. Bits OUT_W-1..16 copy result bit 15 when cfg_sext = 1 and are zero when cfg_sext = 0 (so 0x8000 becomes 0xFF8000 or 0x008000 at OUT_W = 24).
- R8: smp_valid rises the second clock edge after the last capture of a conversion. smp_valid and smp_data hold until smp_ready is seen high. A new sample arriving while smp_valid is high and smp_ready is low replaces the held one and sets err_overrun, which stays set until reset.
- R9: If adc_busy has not risen TIMEOUT_CYC cycles after the conversion pulse began, the block sets err_timeout (sticky until reset), produces no sample for that conversion and returns to idle ready for the next start.
- R10: During reset adc_rc_n = 1, adc_cs_n = 1, adc_byte = 0, smp_valid = 0, err_overrun = 0 and err_timeout = 0.
- R11: With cfg_free_run = 1 and no start_req, conversions repeat back to back at the spacing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_mode | input | 1 | 1 = read the result as two bytes on adc_data[15:8] |
| cfg_free_run | input | 1 | 1 = start conversions continuously |
| cfg_sext | input | 1 | 1 = sign-extend the sample, 0 = zero-extend |
| start_req | input | 1 | Level request for a conversion |
| adc_busy | input | 1 | Converter busy flag (low while converting), asynchronous |
| adc_data | input | 16 | Converter parallel data bus |
| adc_rc_n | output | 1 | Read/convert strobe, low starts a conversion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_byte | output | 1 | Byte select toward the converter |
| smp_ready | input | 1 | Host accepts the held sample |
| smp_valid | output | 1 | A sample is held for the host |
| smp_data | output | OUT_W | Widened two's-complement sample |
| err_overrun | output | 1 | Sticky: a sample was replaced before being accepted |
| err_timeout | output | 1 | Sticky: busy did not return within the timeout |

## Verification
A sequencer stuck in the wrong state shows up at once on the control lines. A missing or stretched convert pulse, a bus enable while busy is low, or a chip-select edge without strobe setup appears within the same conversion, usually within a few cycles of the fault. A capture taken one cycle too early returns the converter's unsettled bus value, and that mismatch reaches smp_data two edges after the capture. A wrong byte order or a lost byte shows on the same sample. Errors in the spacing or timeout counters show only at the next start, or TIMEOUT_CYC cycles after a hung pulse, so those are checked over whole conversion periods.

// File: rtl/sar_rdctl_pkg.sv
package sar_rdctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT,
    ST_RD_HI,
    ST_RD_LO
  } rd_state_e;

  // Two captured halves make one result word.
  function automatic logic [15:0] join_halves(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  // Converter drives its bus only in this control state.
  function automatic logic bus_live(input logic rc_n, input logic cs_n);
    return rc_n & ~cs_n;
  endfunction

  // Converter starts a conversion in this control state.
  function automatic logic convert_on(input logic rc_n, input logic cs_n);
    return ~rc_n & ~cs_n;
  endfunction

endpackage

// File: rtl/rdctl_busy_sync.sv
module rdctl_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_s,
  output logic busy_rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], busy_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign busy_s    = chain_q[STAGES-1];
  assign busy_rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rdctl_seq.sv
module rdctl_seq
  import sar_rdctl_pkg::*;
#(
  parameter int SETUP_CYC   = 4,
  parameter int PULSE_CYC   = 12,
  parameter int ACCESS_CYC  = 23,
  parameter int PERIOD_CYC  = 2500,
  parameter int TIMEOUT_CYC = 2250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_mode,
  input  logic        free_run,
  input  logic        start_req,
  input  logic        busy_rise,
  input  logic [15:0] bus_in,
  output logic        rc_n,
  output logic        cs_n,
  output logic        byte_sel,
  output logic        word_done,
  output logic [15:0] word_out,
  output logic        tmo_evt
);

  localparam int SPAN   = (PERIOD_CYC > TIMEOUT_CYC) ? PERIOD_CYC : TIMEOUT_CYC;
  localparam int CNT_W  = $clog2(SPAN + 1);
  localparam int PH_M1  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int PH_MAX = (PH_M1 > ACCESS_CYC) ? PH_M1 : ACCESS_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  localparam logic [CNT_W-1:0] SPAN_C     = CNT_W'(SPAN);
  localparam logic [CNT_W-1:0] PERIOD_C   = CNT_W'(PERIOD_CYC);
  localparam logic [CNT_W-1:0] TMO_C      = CNT_W'(TIMEOUT_CYC);
  localparam logic [PH_W-1:0]  SETUP_LAST = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  PULSE_LAST = PH_W'(PULSE_CYC - 1);
  localparam logic [PH_W-1:0]  ACC_LAST   = PH_W'(ACCESS_CYC - 1);

  rd_state_e        state_q;
  logic [PH_W-1:0]  ph_cnt;
  logic [CNT_W-1:0] sp_cnt;
  logic             mode_q;
  logic [15:0]      word_q;
  logic             done_q;
  logic             tmo_q;

  logic want_go;
  logic spaced;

  assign want_go = start_req | free_run;
  assign spaced  = (sp_cnt >= PERIOD_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_cnt  <= '0;
      sp_cnt  <= SPAN_C;
      mode_q  <= 1'b0;
      word_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      ph_cnt <= ph_cnt + 1'b1;
      if (sp_cnt != SPAN_C) sp_cnt <= sp_cnt + 1'b1;
      case (state_q)
        ST_IDLE: begin
          ph_cnt <= '0;
          if (want_go && spaced) begin
            state_q <= ST_SETUP;
            mode_q  <= byte_mode;
          end
        end
        ST_SETUP: begin
          if (ph_cnt == SETUP_LAST) begin
            state_q <= ST_PULSE;
            ph_cnt  <= '0;
            sp_cnt  <= '0;
          end
        end
        ST_PULSE: begin
          if (ph_cnt == PULSE_LAST) begin
            state_q <= ST_WAIT;
            ph_cnt  <= '0;
          end
        end
        ST_WAIT: begin
          ph_cnt <= '0;
          if (busy_rise) begin
            state_q <= ST_RD_HI;
          end else if (sp_cnt >= TMO_C) begin
            state_q <= ST_IDLE;
            tmo_q   <= 1'b1;
          end
        end
        ST_RD_HI: begin
          if (ph_cnt == ACC_LAST) begin
            ph_cnt <= '0;
            if (mode_q) begin
              word_q  <= join_halves(bus_in[15:8], word_q[7:0]);
              state_q <= ST_RD_LO;
            end else begin
              word_q  <= bus_in;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_RD_LO: begin
          if (ph_cnt == ACC_LAST) begin
            ph_cnt  <= '0;
            word_q  <= join_halves(word_q[15:8], bus_in[15:8]);
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rc_n     = 1'b1;
    cs_n     = 1'b1;
    byte_sel = 1'b0;
    case (state_q)
      ST_SETUP: rc_n = 1'b0;
      ST_PULSE: begin
        rc_n = 1'b0;
        cs_n = 1'b0;
      end
      ST_RD_HI: cs_n = 1'b0;
      ST_RD_LO: begin
        cs_n     = 1'b0;
        byte_sel = 1'b1;
      end
      default: ;
    endcase
  end

  assign word_done = done_q;
  assign word_out  = word_q;
  assign tmo_evt   = tmo_q;

endmodule

// File: rtl/rdctl_outbuf.sv
module rdctl_outbuf #(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [15:0]      word,
  input  logic             sext,
  input  logic             ready,
  output logic             valid,
  output logic [OUT_W-1:0] data,
  output logic             overrun
);

  // Widen a 16-bit two's-complement result to OUT_W bits.
  function automatic logic [OUT_W-1:0] widen(input logic [15:0] w, input logic sx);
    logic [OUT_W-1:0] r;
    r = OUT_W'(w);
    if (sx && w[15]) r = r | ~OUT_W'(16'hFFFF);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) begin
        if (valid && !ready) overrun <= 1'b1;
        valid <= 1'b1;
        data  <= widen(word, sext);
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_adc_rdctl.sv
module sar_adc_rdctl #(
  parameter int SETUP_CYC   = 4,
  parameter int PULSE_CYC   = 12,
  parameter int ACCESS_CYC  = 23,
  parameter int PERIOD_CYC  = 2500,
  parameter int TIMEOUT_CYC = 2250,
  parameter int OUT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_byte_mode,
  input  logic             cfg_free_run,
  input  logic             cfg_sext,
  input  logic             start_req,
  input  logic             adc_busy,
  input  logic [15:0]      adc_data,
  output logic             adc_rc_n,
  output logic             adc_cs_n,
  output logic             adc_byte,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [OUT_W-1:0] smp_data,
  output logic             err_overrun,
  output logic             err_timeout
);

  // Internal events, named for the bound checker.
  logic        busy_s;
  logic        busy_rise;
  logic        word_done;
  logic [15:0] word_cap;
  logic        tmo_evt;
  logic        tmo_flag;

  rdctl_busy_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (adc_busy),
    .busy_s     (busy_s),
    .busy_rise  (busy_rise)
  );

  rdctl_seq #(
    .SETUP_CYC   (SETUP_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .ACCESS_CYC  (ACCESS_CYC),
    .PERIOD_CYC  (PERIOD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (cfg_byte_mode),
    .free_run  (cfg_free_run),
    .start_req (start_req),
    .busy_rise (busy_rise),
    .bus_in    (adc_data),
    .rc_n      (adc_rc_n),
    .cs_n      (adc_cs_n),
    .byte_sel  (adc_byte),
    .word_done (word_done),
    .word_out  (word_cap),
    .tmo_evt   (tmo_evt)
  );

  rdctl_outbuf #(.OUT_W(OUT_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (word_done),
    .word    (word_cap),
    .sext    (cfg_sext),
    .ready   (smp_ready),
    .valid   (smp_valid),
    .data    (smp_data),
    .overrun (err_overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_flag <= 1'b0;
    else if (tmo_evt) tmo_flag <= 1'b1;
  end

  assign err_timeout = tmo_flag;

endmodule

// File: rtl/sar_adc_rdctl_chk.sv
module sar_adc_rdctl_chk #(
  parameter int PULSE_CYC  = 12,
  parameter int PERIOD_CYC = 2500,
  parameter int OUT_W      = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_rc_n,
  input logic             adc_cs_n,
  input logic             adc_byte,
  input logic             busy_s,
  input logic             word_done,
  input logic             tmo_evt,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [OUT_W-1:0] smp_data,
  input logic             err_overrun,
  input logic             err_timeout
);

  logic        conv;
  logic        conv_q;
  logic [31:0] pw_cnt;
  logic [31:0] gap_cnt;

  assign conv = ~adc_rc_n & ~adc_cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q  <= 1'b0;
      pw_cnt  <= '0;
      gap_cnt <= 32'hFFFF_FFFF;
    end else begin
      conv_q <= conv;
      pw_cnt <= conv ? pw_cnt + 1 : '0;
      if (conv && !conv_q) gap_cnt <= 32'd1;
      else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
    end
  end

  p_pulse_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_q && !conv) |-> (pw_cnt == 32'(PULSE_CYC)));

  p_strobe_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $stable(adc_rc_n));

  p_start_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !conv_q) |-> (gap_cnt >= 32'(PERIOD_CYC)));

  p_read_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_rc_n && !adc_cs_n) |-> busy_s);

  p_byte_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_byte);

  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> smp_valid);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !word_done) |=> $stable(smp_data));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> err_overrun);

  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);

  p_timeout_no_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> !word_done);

endmodule

bind sar_adc_rdctl sar_adc_rdctl_chk #(
  .PULSE_CYC  (PULSE_CYC),
  .PERIOD_CYC (PERIOD_CYC),
  .OUT_W      (OUT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_rc_n    (adc_rc_n),
  .adc_cs_n    (adc_cs_n),
  .adc_byte    (adc_byte),
  .busy_s      (busy_s),
  .word_done   (word_done),
  .tmo_evt     (tmo_evt),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .err_overrun (err_overrun),
  .err_timeout (err_timeout)
);

// File: tb/sar_adc_rdctl_bench.sv
module sar_adc_rdctl_bench;

  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int ACC    = 3;
  localparam int PERIOD = 60;
  localparam int TMO    = 45;
  localparam int OW     = 24;
  localparam int CONV_M = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_byte_mode, cfg_free_run, cfg_sext, start_req;
  logic          adc_busy;
  logic [15:0]   adc_data;
  logic          adc_rc_n, adc_cs_n, adc_byte;
  logic          smp_ready, smp_valid;
  logic [OW-1:0] smp_data;
  logic          err_overrun, err_timeout;

  always #2 clk = ~clk;

  sar_adc_rdctl #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACC),
    .PERIOD_CYC(PERIOD), .TIMEOUT_CYC(TMO), .OUT_W(OW)
  ) u_sar_adc_rdctl (
    .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode), .cfg_free_run(cfg_free_run),
    .cfg_sext(cfg_sext), .start_req(start_req), .adc_busy(adc_busy), .adc_data(adc_data),
    .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n), .adc_byte(adc_byte), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_data(smp_data), .err_overrun(err_overrun), .err_timeout(err_timeout)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] gen_word(input int idx);
    case (idx)
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0000;
      default: return 16'((idx * 40573) ^ 16'h1C35);
    endcase
  endfunction

  function automatic logic [OW-1:0] expect_ext(input logic [15:0] w, input logic sx);
    if (sx && w[15]) return {8'hFF, w};
    return {8'h00, w};
  endfunction

  // Behavioural converter and reference model state.
  logic [15:0] q[$];
  bit          busy_m, hang, orphan;
  int          ccnt, starts, gap, pw, rc_run, en_run, accepted;
  logic [15:0] cur_word, out_reg;
  bit          conv_prev, cs_prev, rc_prev, en_prev, byte_prev;
  bit          push_pend, rdy_prev, exp_valid, exp_ovr;
  logic [OW-1:0] exp_data;
  int          rdy_mode;
  int          cyc;

  always @(negedge clk) begin
    bit conv_now, en_now;
    cyc++;
    if (!rst_n) begin
      q.delete();
      busy_m = 1; ccnt = 0; starts = 0; gap = 1000000; pw = 0; rc_run = 0; en_run = 0;
      accepted = 0; out_reg = 16'h0; cur_word = 16'h0;
      conv_prev = 0; cs_prev = 1; rc_prev = 1; en_prev = 0; byte_prev = 0;
      push_pend = 0; rdy_prev = 0; exp_valid = 0; exp_ovr = 0; exp_data = '0;
      adc_busy = 1; adc_data = 16'h0; smp_ready = 0;
    end else begin
      // output buffer reference: effect of the edge just passed
      if (push_pend) begin
        if (exp_valid && !rdy_prev) exp_ovr = 1;
        if (exp_valid && rdy_prev) accepted++;
        exp_valid = 1;
        if (q.size() == 0) chk(0, "R5 missing expected word", 0, 1);
        else exp_data = expect_ext(q.pop_front(), cfg_sext);
      end else if (exp_valid && rdy_prev) begin
        exp_valid = 0;
        accepted++;
      end
      chk(smp_valid == exp_valid, "R8 smp_valid", 32'(smp_valid), 32'(exp_valid));
      if (exp_valid)
        chk(smp_data == exp_data, cfg_byte_mode ? "R6 R7 byte-mode sample" : "R5 R7 word sample",
            32'(smp_data), 32'(exp_data));
      chk(err_overrun == exp_ovr, "R8 err_overrun", 32'(err_overrun), 32'(exp_ovr));

      conv_now = !adc_rc_n && !adc_cs_n;
      en_now   = adc_rc_n && !adc_cs_n;

      if (!conv_now && conv_prev) chk(pw == PULSE, "R1 pulse width", 32'(pw), 32'(PULSE));
      pw = conv_now ? pw + 1 : 0;

      if (!adc_cs_n && cs_prev)
        chk((adc_rc_n == rc_prev) && (rc_run >= SETUP), "R2 strobe setup", 32'(rc_run), 32'(SETUP));
      rc_run = (adc_rc_n == rc_prev) ? rc_run + 1 : 1;

      if (adc_cs_n) chk(adc_byte == 1'b0, "R6 byte idle", 32'(adc_byte), 0);
      if (en_now && !cfg_byte_mode && !adc_byte) chk(1, "R5", 0, 0);

      if (conv_now && !conv_prev) begin
        chk(gap >= PERIOD, "R3 start spacing", 32'(gap), 32'(PERIOD));
        starts++;
        gap = 0;
        busy_m = 0;
        ccnt = 0;
        cur_word = gen_word(starts);
      end else if (!busy_m && !hang) begin
        ccnt++;
        if (ccnt == CONV_M) begin
          busy_m = 1;
          out_reg = cur_word;
          if (orphan) orphan = 0;
          else q.push_back(cur_word);
        end
      end
      if (gap < 1000000) gap++;

      if (en_now) chk(busy_m, "R4 bus enabled while busy low", 0, 1);

      push_pend = adc_cs_n && !cs_prev && rc_prev;

      if (en_now && en_prev && (adc_byte == byte_prev)) en_run++;
      else if (en_now) en_run = 1;
      else en_run = 0;
      if (en_run >= ACC) adc_data = adc_byte ? {out_reg[7:0], out_reg[15:8]} : out_reg;
      else adc_data = out_reg ^ 16'hA5C3;
      adc_busy = busy_m;

      case (rdy_mode)
        0: smp_ready = 0;
        1: smp_ready = 1;
        default: smp_ready = (cyc % 3) != 0;
      endcase
      rdy_prev  = smp_ready;
      conv_prev = conv_now;
      cs_prev   = adc_cs_n;
      rc_prev   = adc_rc_n;
      en_prev   = en_now;
      byte_prev = adc_byte;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(0, "watchdog expired", 32'(cyc), 150000);
      report();
    end
  end

  task automatic one_conv();
    int target;
    target = starts + 1;
    start_req = 1;
    while (starts < target) @(negedge clk);
    start_req = 0;
    repeat (PERIOD + 10) @(negedge clk);
  endtask

  initial begin
    int s0;
    rst_n = 0; cfg_byte_mode = 0; cfg_free_run = 0; cfg_sext = 0; start_req = 0;
    hang = 0; orphan = 0; rdy_mode = 1; cyc = 0;
    adc_busy = 1; adc_data = 0; smp_ready = 0;
    repeat (5) @(negedge clk);
    chk(adc_rc_n == 1, "R10 rc_n in reset", 32'(adc_rc_n), 1);
    chk(adc_cs_n == 1, "R10 cs_n in reset", 32'(adc_cs_n), 1);
    chk(adc_byte == 0, "R10 byte in reset", 32'(adc_byte), 0);
    chk(smp_valid == 0, "R10 valid in reset", 32'(smp_valid), 0);
    chk(err_overrun == 0 && err_timeout == 0, "R10 flags in reset",
        32'({err_overrun, err_timeout}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // word mode, sign extension, full-scale codes
    cfg_sext = 1;
    for (int i = 0; i < 4; i++) one_conv();
    chk(accepted == 4, "R5 R7 word samples accepted", 32'(accepted), 4);

    // byte mode, zero extension, irregular ready
    cfg_byte_mode = 1; cfg_sext = 0; rdy_mode = 2;
    for (int i = 0; i < 4; i++) one_conv();
    repeat (10) @(negedge clk);
    chk(accepted == 8, "R6 byte samples accepted", 32'(accepted), 8);

    // overrun: host stalls across two samples
    cfg_sext = 1; rdy_mode = 0;
    one_conv();
    one_conv();
    chk(err_overrun == 1, "R8 overrun set", 32'(err_overrun), 1);
    chk(smp_valid == 1, "R8 valid held while stalled", 32'(smp_valid), 1);
    rdy_mode = 1;
    repeat (5) @(negedge clk);
    chk(smp_valid == 0, "R8 drained", 32'(smp_valid), 0);
    chk(err_overrun == 1, "R8 overrun sticky", 32'(err_overrun), 1);

    // no request, no conversion
    s0 = starts;
    repeat (200) @(negedge clk);
    chk(starts == s0, "R3 idle without request", 32'(starts), 32'(s0));

    // free-running
    cfg_byte_mode = 0; cfg_free_run = 1;
    s0 = starts;
    repeat (200) @(negedge clk);
    cfg_free_run = 0;
    repeat (PERIOD + 20) @(negedge clk);
    chk(starts - s0 >= 3, "R11 free-run starts", 32'(starts - s0), 3);

    // timeout: converter never finishes
    chk(err_timeout == 0, "R9 no timeout yet", 32'(err_timeout), 0);
    hang = 1;
    s0 = accepted;
    one_conv();
    chk(err_timeout == 1, "R9 timeout flagged", 32'(err_timeout), 1);
    chk(smp_valid == 0, "R9 no sample on timeout", 32'(smp_valid), 0);
    orphan = 1;
    hang = 0;
    repeat (40) @(negedge clk);
    one_conv();
    chk(accepted == s0 + 1, "R9 recovery sample", 32'(accepted), 32'(s0 + 1));
    chk(err_timeout == 1, "R9 timeout sticky", 32'(err_timeout), 1);

    report();
  end

endmodule